// File: doc/BRIEF.md
# Addressable Switch ROM Controller

This block is the command engine of a slave on a single-wire bus. The slave owns a 64-bit identity and one open-drain switch output. The analog slot timing is handled elsewhere. The block receives only bit-level events:

- a strobe marking a bus reset pulse;
- write-slot strobes, each carrying the bit the master wrote;
- read-slot strobes, which consume the bit the block currently offers on `rd_data`;
- the raw bus-low level, used to detect a stuck-low bus.

After each reset pulse the block raises a one-cycle presence indication. It then collects an 8-bit command, least significant bit first. The command can read out the identity, compare an address against it, or select the device without an address.

When the device is addressed, by a full 64-bit match or by the select-without-address command, the switch output flips. From then on every read slot returns the level sensed on the switch pin, until the next reset pulse. A device that is not addressed, or that receives an unknown command, stays silent (reads return 1) until the next reset pulse. A bus held low for longer than the timeout window forces the switch off. An ordinary reset pulse leaves the switch as it was.

The identity holds three fields, from the low byte up:

- family code 05h in bits 7:0;
- a 48-bit serial number in bits 55:8;
- an 8-bit check byte in bits 63:56.

The check byte is computed when the design is built, from the low 56 bits.

Top module: `addr_switch_ctrl`

## Requirements
- R1: While rst_n is low and in the first cycle after it, pio_on is 0, presence is 0 and rd_data is 1.
- R2: A bus_reset strobe, when no timeout occurs in the same cycle, makes presence 1 for exactly the following cycle.
- R3: Command 33h (bits sent LSB first) makes the next 64 read slots return the identity LSB first. The identity is family 05h in bits 7:0, SERIAL in bits 55:8, and in bits 63:56 a CRC over bits 55:0. The CRC is polynomial x^8+x^5+x^4+1 in reflected form, initial value 0, data taken LSB first. After the 64th slot, reads return 1.
- R4: Command 55h followed by 64 written bits equal to the identity (LSB first) inverts pio_on. The new value is visible in the cycle after the 64th write strobe. After 63 bits pio_on is unchanged.
- R5: During an address compare, a written bit that differs from the identity ends the transaction. pio_on stays unchanged, later writes have no effect, and reads return 1 until the next bus_reset.
- R6: After the device has been addressed, every read slot returns the current level of pio_sense, until the next bus_reset.
- R7: Command CCh inverts pio_on in the cycle after its 8th bit is written, and then behaves as an addressed device.
- R8: Any command other than 33h, 55h and CCh makes reads return 1, and writes have no effect on pio_on, until the next bus_reset.
- R9: bus_low high on CLKS_PER_US*TIMEOUT_US consecutive clock edges forces pio_on to 0 on the last of those edges, and the device waits for a bus_reset. One edge fewer leaves pio_on unchanged.
- R10: A bus_reset strobe without a timeout leaves pio_on unchanged.
- R11: Before the first bus_reset after rst_n, write and read slots have no effect: reads return 1 and pio_on stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | One-cycle strobe: reset pulse seen on the bus |
| bus_low | input | 1 | Bus line is currently low (timeout detection) |
| wr_strobe | input | 1 | One-cycle strobe: write slot, bit in wr_bit |
| wr_bit | input | 1 | Bit written by the master |
| rd_strobe | input | 1 | One-cycle strobe: read slot consumes rd_data |
| rd_data | output | 1 | Bit returned in the next read slot (1 = released) |
| presence | output | 1 | One-cycle presence indication after bus_reset |
| pio_sense | input | 1 | Sensed level of the switch pin |
| pio_on | output | 1 | Switch pulldown enabled |

## Verification
Some rules hold on every cycle, and the bound checker covers those:

- presence appears only after a reset strobe, and always after one;
- the switch changes only after a write slot or a timeout;
- a timeout always leaves the switch off;
- a plain reset pulse never moves the switch.

Other behaviour depends on a whole transaction, and only the bench scenarios show it:

- the identity bit order and its check byte;
- exactly when the 64th matching bit flips the switch;
- that a single wrong address bit, or an unknown command, leaves the device silent;
- the exact length of the timeout window.

// File: rtl/asw_pkg.sv
// Package: shared state and command types, plus the check-byte function
// used to build the identity when the design is elaborated.
package asw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_REPORT
    } ctl_state_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_MATCH,
        OP_SKIP,
        OP_BAD
    } rom_op_e;

    localparam logic [7:0] CMD_READ  = 8'h33;
    localparam logic [7:0] CMD_MATCH = 8'h55;
    localparam logic [7:0] CMD_SKIP  = 8'hCC;

    // Reflected CRC-8 (x^8+x^5+x^4+1), initial value 0, data taken LSB first.
    function automatic logic [7:0] crc8_lsb(input logic [55:0] data);
        logic [7:0] acc;
        logic       fb;
        acc = 8'h00;
        for (int i = 0; i < 56; i++) begin
            fb  = acc[0] ^ data[i];
            acc = acc >> 1;
            if (fb) acc = acc ^ 8'h8C;
        end
        return acc;
    endfunction

endpackage

// File: rtl/asw_cmd_decode.sv
// Command decoder: maps a received command byte onto a ROM operation.
// Assumes the byte is complete (all 8 bits shifted in).
module asw_cmd_decode
    import asw_pkg::*;
(
    input  logic [7:0] code,
    output rom_op_e    op
);
    // Pick the operation for the command code; anything unknown is OP_BAD.
    always_comb begin
        case (code)
            CMD_READ:  op = OP_READ;
            CMD_MATCH: op = OP_MATCH;
            CMD_SKIP:  op = OP_SKIP;
            default:   op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/asw_id_bits.sv
// Identity source: builds the 64-bit identity from family code and serial
// number, appends the computed check byte, and returns the bit at idx.
// Assumes idx is within the identity width.
module asw_id_bits
    import asw_pkg::*;
#(
    parameter int          FAM_W   = 8,
    parameter int          SER_W   = 48,
    parameter logic [7:0]  FAMILY  = 8'h05,
    parameter logic [47:0] SERIAL  = 48'h0,
    localparam int         ID_W    = FAM_W + SER_W + 8,
    localparam int         IDX_W   = $clog2(ID_W)
) (
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    localparam logic [55:0]     BODY = {SERIAL, FAMILY};
    localparam logic [7:0]      CHK  = crc8_lsb(BODY);
    localparam logic [ID_W-1:0] ID   = {CHK, BODY};

    // Select the requested identity bit.
    assign bit_o = ID[idx];
endmodule

// File: rtl/asw_bus_timeout.sv
// Stuck-low detector: counts consecutive clock edges with the bus low and
// gives a one-cycle hit when the count reaches CLKS_PER_US*TIMEOUT_US.
// Assumes bus_low is already synchronised to clk. A limit of 0 disables it.
module asw_bus_timeout #(
    parameter int CLKS_PER_US = 100,
    parameter int TIMEOUT_US  = 120,
    localparam int LIMIT      = CLKS_PER_US * TIMEOUT_US,
    localparam int CNT_W      = $clog2(LIMIT + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_low,
    output logic hit
);
    generate
        if (LIMIT == 0) begin : g_off
            assign hit = 1'b0;
        end else begin : g_on
            logic [CNT_W-1:0] low_cnt;

            // Count edges with the bus low, saturating at the limit.
            always_ff @(posedge clk) begin
                if (!rst_n || !bus_low) low_cnt <= '0;
                else if (low_cnt != CNT_W'(LIMIT)) low_cnt <= low_cnt + 1'b1;
            end

            // Fire on the edge that completes the window.
            assign hit = bus_low && (low_cnt == CNT_W'(LIMIT - 1));
        end
    endgenerate
endmodule

// File: rtl/addr_switch_ctrl.sv
// Addressable switch ROM controller (top). Takes bit-level bus events,
// decodes the ROM command, serves identity read-out and address compare,
// toggles the switch when addressed, and then reports the pin level.
// Assumes every strobe lasts one cycle and inputs are synchronous to clk.
module addr_switch_ctrl
    import asw_pkg::*;
#(
    parameter logic [47:0] SERIAL      = 48'h1234_5678_9ABC,
    parameter int          CLKS_PER_US = 100,
    parameter int          TIMEOUT_US  = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic bus_low,
    input  logic wr_strobe,
    input  logic wr_bit,
    input  logic rd_strobe,
    output logic rd_data,
    output logic presence,
    input  logic pio_sense,
    output logic pio_on
);
    localparam int         ID_W    = 64;
    localparam int         IDX_W   = $clog2(ID_W);
    localparam int         CMD_W   = 8;
    localparam logic [7:0] FAMILY  = 8'h05;

    ctl_state_e       state;
    logic [IDX_W-1:0] cnt;
    logic [CMD_W-1:0] cmd;
    logic [CMD_W-1:0] cmd_next;
    rom_op_e          op;
    logic             id_bit;
    logic             tmo_hit;

    assign cmd_next = {wr_bit, cmd[CMD_W-1:1]};

    asw_cmd_decode u_dec (
        .code (cmd_next),
        .op   (op)
    );

    asw_id_bits #(
        .FAMILY (FAMILY),
        .SERIAL (SERIAL)
    ) u_id (
        .idx   (cnt),
        .bit_o (id_bit)
    );

    asw_bus_timeout #(
        .CLKS_PER_US (CLKS_PER_US),
        .TIMEOUT_US  (TIMEOUT_US)
    ) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_low (bus_low),
        .hit     (tmo_hit)
    );

    // Transaction sequencer: timeout beats reset pulse, which beats slot strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cmd      <= '0;
            pio_on   <= 1'b0;
            presence <= 1'b0;
        end else begin
            presence <= 1'b0;
            if (tmo_hit) begin
                state  <= ST_IDLE;
                pio_on <= 1'b0;
            end else if (bus_reset) begin
                state    <= ST_CMD;
                cnt      <= '0;
                presence <= 1'b1;
            end else begin
                case (state)
                    ST_CMD: begin
                        if (wr_strobe) begin
                            cmd <= cmd_next;
                            cnt <= cnt + 1'b1;
                            if (cnt == IDX_W'(CMD_W - 1)) begin
                                cnt <= '0;
                                case (op)
                                    OP_READ:  state <= ST_READ;
                                    OP_MATCH: state <= ST_MATCH;
                                    OP_SKIP: begin
                                        pio_on <= ~pio_on;
                                        state  <= ST_REPORT;
                                    end
                                    default:  state <= ST_IDLE;
                                endcase
                            end
                        end
                    end
                    ST_READ: begin
                        if (rd_strobe) begin
                            cnt <= cnt + 1'b1;
                            if (cnt == IDX_W'(ID_W - 1)) state <= ST_IDLE;
                        end
                    end
                    ST_MATCH: begin
                        if (wr_strobe) begin
                            cnt <= cnt + 1'b1;
                            if (wr_bit != id_bit) begin
                                state <= ST_IDLE;
                            end else if (cnt == IDX_W'(ID_W - 1)) begin
                                pio_on <= ~pio_on;
                                state  <= ST_REPORT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Offer the next read bit: identity bit, pin level, or released bus.
    always_comb begin
        case (state)
            ST_READ:   rd_data = id_bit;
            ST_REPORT: rd_data = pio_sense;
            default:   rd_data = 1'b1;
        endcase
    end
endmodule

// File: rtl/addr_switch_ctrl_chk.sv
// Checker for addr_switch_ctrl: cycle-level rules on presence and switch.
// Assumes it is bound into the top so that it sees the internal timeout hit.
module addr_switch_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_reset,
    input logic wr_strobe,
    input logic tmo_hit,
    input logic presence,
    input logic pio_on
);
    // R2
    presence_follows_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !tmo_hit) |=> presence);

    // R2
    presence_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        presence |-> $past(bus_reset));

    // R4
    switch_moves_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pio_on) |-> ($past(wr_strobe) || $past(tmo_hit)));

    // R9
    timeout_clears_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_hit |=> !pio_on);

    // R10
    reset_keeps_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !tmo_hit) |=> (pio_on == $past(pio_on)));
endmodule

bind addr_switch_ctrl addr_switch_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .wr_strobe (wr_strobe),
    .tmo_hit   (tmo_hit),
    .presence  (presence),
    .pio_on    (pio_on)
);

// File: tb/sim_addr_switch_ctrl.sv
module sim_addr_switch_ctrl;
    localparam logic [47:0] SER  = 48'hA1B2_C3D4_E5F6;
    localparam int          CPU  = 2;
    localparam int          TUS  = 120;
    localparam int          LIM  = CPU * TUS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0, bus_low = 1'b0;
    logic wr_strobe = 1'b0, wr_bit = 1'b0, rd_strobe = 1'b0;
    logic ext_low = 1'b0;
    logic rd_data, presence, pio_on, pio_sense;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [63:0] ident;
    logic  exp_q[$];
    string tag_q[$];

    always #5 clk = ~clk;

    // Pin model: pullup, pulldown from the switch, optional external pull-low.
    assign pio_sense = ext_low ? 1'b0 : ~pio_on;

    addr_switch_ctrl #(.SERIAL(SER), .CLKS_PER_US(CPU), .TIMEOUT_US(TUS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .bus_low(bus_low),
        .wr_strobe(wr_strobe), .wr_bit(wr_bit), .rd_strobe(rd_strobe),
        .rd_data(rd_data), .presence(presence), .pio_sense(pio_sense), .pio_on(pio_on)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [55:0] d);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < 56; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 8'h8C;
            else             c = c >> 1;
        end
        return c;
    endfunction

    task automatic wr(input logic b);
        @(posedge clk); #1 wr_strobe = 1'b1; wr_bit = b;
        @(posedge clk); #1 wr_strobe = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wr(v[i]);
    endtask

    // Driver: push expected read bit, then issue the slot.
    task automatic rd(input logic e, input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(posedge clk); #1 rd_strobe = 1'b1;
        @(posedge clk); #1 rd_strobe = 1'b0;
    endtask

    task automatic breset(input string req);
        @(posedge clk); #1 bus_reset = 1'b1;
        @(posedge clk); #1 bus_reset = 1'b0;
        chk(req, presence, 1);
        @(posedge clk); #1 chk(req, presence, 0);
    endtask

    // Monitor: compare each read slot's bit against the scoreboard.
    always @(negedge clk) begin
        if (rd_strobe) begin
            if (exp_q.size() == 0) chk("scoreboard_empty", 1, 0);
            else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        ident = {ref_crc({SER, 8'h05}), SER, 8'h05};
        repeat (3) @(posedge clk);
        #1 chk("R1 pio", pio_on, 0); chk("R1 presence", presence, 0); chk("R1 rd", rd_data, 1);
        rst_n = 1'b1;
        @(posedge clk); #1 chk("R1 after", {pio_on, presence, rd_data}, 3'b001);

        // R11: slots before the first reset pulse are ignored
        wr_byte(8'hCC);
        rd(1'b1, "R11 read");
        chk("R11 pio", pio_on, 0);

        // R2, R3: identity read-out
        breset("R2");
        wr_byte(8'h33);
        for (int i = 0; i < 64; i++) rd(ident[i], "R3 id bit");
        rd(1'b1, "R3 after 64");

        // R4: full match toggles after 64th bit
        breset("R2");
        wr_byte(8'h55);
        for (int i = 0; i < 63; i++) wr(ident[i]);
        chk("R4 after 63", pio_on, 0);
        wr(ident[63]);
        chk("R4 after 64", pio_on, 1);
        rd(1'b0, "R6 on");
        rd(1'b0, "R6 on again");

        // R10: reset pulse keeps switch
        breset("R10");
        chk("R10 pio kept", pio_on, 1);

        // R6: match again turns off; external pull-low is reported
        wr_byte(8'h55);
        for (int i = 0; i < 64; i++) wr(ident[i]);
        chk("R4 toggle off", pio_on, 0);
        rd(1'b1, "R6 off");
        #1 ext_low = 1'b1;
        rd(1'b0, "R6 ext low");
        #1 ext_low = 1'b0;

        // R5: one wrong bit ends the transaction
        breset("R2");
        wr_byte(8'h55);
        for (int i = 0; i < 64; i++) wr(i == 10 ? ~ident[i] : ident[i]);
        chk("R5 pio", pio_on, 0);
        rd(1'b1, "R5 silent");

        // R7: select without address toggles
        breset("R2");
        wr_byte(8'hCC);
        chk("R7 pio", pio_on, 1);
        rd(1'b0, "R7 report");

        // R8: unknown command
        breset("R8");
        wr_byte(8'hA5);
        rd(1'b1, "R8 silent");
        wr_byte(8'hCC);
        chk("R8 pio", pio_on, 1);

        // R9: stuck-low window
        @(posedge clk); #1 bus_low = 1'b1;
        repeat (LIM - 1) @(posedge clk);
        #1 chk("R9 before", pio_on, 1);
        @(posedge clk); #1 chk("R9 at limit", pio_on, 0);
        bus_low = 1'b0;
        rd(1'b1, "R9 idle");
        breset("R9 recover");
        wr_byte(8'hCC);
        chk("R9 recover pio", pio_on, 1);

        repeat (3) @(posedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule